// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block sequences a successive-approximation analog-to-digital conversion. A start pulse loads a trial code with only the MSB set. When start drops, the block tests one bit per clock, from the MSB down. It uses a single comparator decision to keep or clear each trial bit, and each decision also sets the next lower bit as the new trial. The trial register drives an external DAC. In the bench the DAC and comparator are an ideal compare against a target code.

A short-cycle select chooses between a full 10-bit conversion and an 8-decision conversion. In the short mode the unused low bits are left at fixed values. During the decisions each decided bit is also sent out MSB first as an NRZ serial stream, with a sync strobe that rises mid-bit. After completion the result stays readable through two byte-lane enables until the next start, and a third enable gates the status output. High-impedance outputs are modelled as zeroed data plus output-enable flags.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset the trial code is 0, the status reads complete (1) and the serial output enable is low.
- R2: On any clock edge where start_i is sampled high, the trial code becomes 10'b1000000000 and status becomes 0. This also applies in the middle of a conversion, which then starts over from the MSB.
- R3: The first edge that samples start_i low only arms the sequence. The MSB is decided on the next edge, and each lower bit is decided on the edge after that.
- R4: At a decision, comp_i = 1 means the DAC output exceeds the input and clears the trial bit; comp_i = 0 keeps it at 1. In the same edge the next lower bit, if any, is set to 1.
- R5: With full_res_i = 1, all 10 bits are decided and the final code equals the target of an ideal comparator.
- R6: With full_res_i = 0 (latched at start), only bits 9..2 are decided. The final bits 9..2 equal the target's, bit 1 reads 1 and bit 0 reads 0.
- R7: Status rises to 1 on the edge after the last decision.
- R8: ser_oe_o is high for exactly one clock after each decision and low otherwise. While it is high, ser_o carries the bit just decided (1 = kept), MSB first.
- R9: sync_o gives one rising edge in the middle of each serial bit: 10 per conversion in full mode, 8 in short mode.
- R10: rd_data_o[9:8] is driven only while hi_en_i = 1 and rd_data_o[7:0] only while lo_en_i = 1; otherwise they read 0 and the matching oe flag is low. done_o is driven only while stat_en_i = 1.
- R11: After completion the code stays unchanged until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start/restart request, level sampled |
| comp_i | input | 1 | Comparator: 1 = DAC output above input |
| full_res_i | input | 1 | 1 = 10 decisions, 0 = 8 decisions |
| hi_en_i | input | 1 | Enable for upper 2 result bits |
| lo_en_i | input | 1 | Enable for lower 8 result bits |
| stat_en_i | input | 1 | Enable for status output |
| trial_o | output | 10 | Trial code to the DAC |
| rd_data_o | output | 10 | Gated parallel result |
| rd_hi_oe_o | output | 1 | Upper lane driven |
| rd_lo_oe_o | output | 1 | Lower lane driven |
| done_o | output | 1 | Status, 1 = complete (gated) |
| done_oe_o | output | 1 | Status driven |
| ser_o | output | 1 | Serial NRZ data |
| ser_oe_o | output | 1 | Serial data and sync driven |
| sync_o | output | 1 | Mid-bit serial sync strobe |

## Verification
A restart can coincide with a decision, most sharply with the final one, where the transition to complete would otherwise begin. The bench raises start so that it is sampled on the edge of the last full-mode decision and also a few bits into a conversion. It then requires the restart to win: status stays 0, the code reloads the MSB, and the next run yields the correct code with a fresh sync count. A cycle-accurate behavioural model is compared on every clock, so a lost or doubled decision shows up at once.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2,
    ST_TAIL = 2'd3
  } sar_state_t;
endpackage

// File: rtl/sar_seq.sv
module sar_seq import sar_pkg::*; #(
  parameter int WIDTH      = 10,
  parameter int SHORT_BITS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             comp_i,
  input  logic             full_res_i,
  output logic [WIDTH-1:0] trial_o,
  output logic             done_o,
  output logic             decide_o
);
  localparam int IDX_W     = $clog2(WIDTH);
  localparam int SHORT_END = WIDTH - SHORT_BITS;

  sar_state_t       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [WIDTH-1:0] trial_q, trial_d;
  logic             done_q, full_q;
  logic [IDX_W-1:0] last_idx;

  assign last_idx = full_q ? '0 : IDX_W'(SHORT_END);
  assign decide_o = (state_q == ST_RUN) && !start_i;

  always_comb begin
    trial_d = trial_q;
    for (int i = 0; i < WIDTH; i++) begin
      if (i == int'(idx_q)) begin
        if (comp_i) trial_d[i] = 1'b0;
      end else if (i + 1 == int'(idx_q)) begin
        trial_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      trial_q <= '0;
      done_q  <= 1'b1;
      full_q  <= 1'b1;
    end else if (start_i) begin
      state_q <= ST_ARM;
      idx_q   <= IDX_W'(WIDTH - 1);
      trial_q <= {1'b1, {(WIDTH-1){1'b0}}};
      done_q  <= 1'b0;
      full_q  <= full_res_i;
    end else begin
      unique case (state_q)
        ST_ARM: state_q <= ST_RUN;
        ST_RUN: begin
          trial_q <= trial_d;
          if (idx_q == last_idx) state_q <= ST_TAIL;
          else                   idx_q   <= idx_q - 1'b1;
        end
        ST_TAIL: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign trial_o = trial_q;
  assign done_o  = done_q;

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (trial_q == {1'b1, {(WIDTH-1){1'b0}}}) && !done_q);
  // R4: a comparator 1 at a decision clears the bit under test
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_o && comp_i) |=> !trial_q[$past(idx_q)]);
  a_r6_short_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_q) && !full_q) |-> (trial_q[SHORT_END-1:0] == {1'b1, {(SHORT_END-1){1'b0}}}));
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !start_i) |=> $stable(trial_q));
endmodule

// File: rtl/sar_serial.sv
module sar_serial (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic decide_i,
  input  logic comp_i,
  input  logic done_i,
  output logic ser_o,
  output logic ser_oe_o,
  output logic sync_o
);
  logic ser_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (start_i) begin
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= decide_i;
      if (decide_i) ser_q <= ~comp_i;
    end
  end

  assign ser_o    = ser_q & oe_q;
  assign ser_oe_o = oe_q;
  // rises at the falling clock edge, i.e. mid-bit
  assign sync_o   = oe_q & ~clk_i;

  a_r8_quiet_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !oe_q);
endmodule

// File: rtl/sar_readout.sv
module sar_readout #(
  parameter int WIDTH   = 10,
  parameter int LO_BITS = 8
) (
  input  logic [WIDTH-1:0] code_i,
  input  logic             done_i,
  input  logic             hi_en_i,
  input  logic             lo_en_i,
  input  logic             stat_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             rd_hi_oe_o,
  output logic             rd_lo_oe_o,
  output logic             done_o,
  output logic             done_oe_o
);
  localparam int HI_BITS = WIDTH - LO_BITS;

  assign rd_data_o[WIDTH-1:LO_BITS] = hi_en_i ? code_i[WIDTH-1:LO_BITS] : {HI_BITS{1'b0}};
  assign rd_data_o[LO_BITS-1:0]     = lo_en_i ? code_i[LO_BITS-1:0]     : {LO_BITS{1'b0}};
  assign rd_hi_oe_o = hi_en_i;
  assign rd_lo_oe_o = lo_en_i;
  assign done_o     = done_i & stat_en_i;
  assign done_oe_o  = stat_en_i;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int WIDTH      = 10,
  parameter int SHORT_BITS = 8,
  parameter int LO_BITS    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             comp_i,
  input  logic             full_res_i,
  input  logic             hi_en_i,
  input  logic             lo_en_i,
  input  logic             stat_en_i,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             rd_hi_oe_o,
  output logic             rd_lo_oe_o,
  output logic             done_o,
  output logic             done_oe_o,
  output logic             ser_o,
  output logic             ser_oe_o,
  output logic             sync_o
);
  logic done_raw, decide;

  sar_seq #(.WIDTH(WIDTH), .SHORT_BITS(SHORT_BITS)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .comp_i(comp_i),
    .full_res_i(full_res_i), .trial_o(trial_o), .done_o(done_raw), .decide_o(decide)
  );

  sar_serial u_serial (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .decide_i(decide),
    .comp_i(comp_i), .done_i(done_raw), .ser_o(ser_o), .ser_oe_o(ser_oe_o), .sync_o(sync_o)
  );

  sar_readout #(.WIDTH(WIDTH), .LO_BITS(LO_BITS)) u_rd (
    .code_i(trial_o), .done_i(done_raw), .hi_en_i(hi_en_i), .lo_en_i(lo_en_i),
    .stat_en_i(stat_en_i), .rd_data_o(rd_data_o), .rd_hi_oe_o(rd_hi_oe_o),
    .rd_lo_oe_o(rd_lo_oe_o), .done_o(done_o), .done_oe_o(done_oe_o)
  );

  a_r7_done_after_decide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_raw) |-> $past(ser_oe_o) && !$past(start_i));
endmodule

// File: tb/tb_sar_conv_ctrl.sv
`timescale 1ns/1ps
module tb_sar_conv_ctrl;
  localparam int W = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, full = 1'b1, hi_en = 1'b1, lo_en = 1'b1, st_en = 1'b1;
  logic comp;
  logic [W-1:0] trial, rd_data;
  logic rd_hi_oe, rd_lo_oe, done, done_oe, ser, ser_oe, sync;
  int target = 0;
  int errors = 0, checks = 0, cycles = 0, sync_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign comp = (int'(trial) > target);

  sar_conv_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .comp_i(comp), .full_res_i(full),
    .hi_en_i(hi_en), .lo_en_i(lo_en), .stat_en_i(st_en), .trial_o(trial),
    .rd_data_o(rd_data), .rd_hi_oe_o(rd_hi_oe), .rd_lo_oe_o(rd_lo_oe), .done_o(done),
    .done_oe_o(done_oe), .ser_o(ser), .ser_oe_o(ser_oe), .sync_o(sync)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: stage 0 idle, 1 armed, 2 deciding, 3 finishing
  int m_trial = 0, m_stage = 0, m_bit = 0, m_last = 0;
  bit m_done = 1, m_oe = 0, m_ser = 0, m_full = 1, m_on = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_trial = 0; m_stage = 0; m_done = 1; m_oe = 0; m_ser = 0;
    end else if (start) begin
      m_trial = 1 << (W-1); m_stage = 1; m_done = 0; m_oe = 0;
      m_full = full; m_bit = W-1; m_last = full ? 0 : 2;
    end else begin
      m_oe = 0;
      case (m_stage)
        1: m_stage = 2;
        2: begin
          bit c;
          c = (m_trial > target);
          if (c) m_trial = m_trial & ~(1 << m_bit);
          m_ser = !c; m_oe = 1;
          if (m_bit > 0) m_trial = m_trial | (1 << (m_bit-1));
          if (m_bit == m_last) m_stage = 3; else m_bit--;
        end
        3: begin m_stage = 0; m_done = 1; end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (m_on) begin
      int exp_rd;
      exp_rd = (hi_en ? (m_trial & 'h300) : 0) | (lo_en ? (m_trial & 'hff) : 0);
      chk(int'(trial) == m_trial, "R4 trial per cycle", int'(trial), m_trial);
      chk(done == (m_done & st_en), "R7 status per cycle", int'(done), int'(m_done & st_en));
      chk(ser_oe == m_oe, "R8 serial enable", int'(ser_oe), int'(m_oe));
      if (m_oe) chk(ser == m_ser, "R8 serial bit", int'(ser), int'(m_ser));
      chk(int'(rd_data) == exp_rd, "R10 readout", int'(rd_data), exp_rd);
      chk(rd_hi_oe == hi_en && rd_lo_oe == lo_en && done_oe == st_en, "R10 enables",
          int'({rd_hi_oe, rd_lo_oe, done_oe}), int'({hi_en, lo_en, st_en}));
    end
  end

  always @(posedge sync) sync_cnt++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic convert(input int tgt, input bit f, input int restart_k);
    int n, exp_code;
    @(negedge clk);
    target = tgt; full = f; start = 1'b1;
    @(negedge clk);
    // R2: loaded MSB-only, busy
    chk(trial == 10'h200 && !done, "R2 load", int'(trial), 'h200);
    @(negedge clk);
    start = 1'b0; sync_cnt = 0;
    if (restart_k >= 0) begin
      repeat (restart_k) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      chk(trial == 10'h200 && !done, "R2 restart", int'(trial), 'h200);
      start = 1'b0; sync_cnt = 0;
    end
    // R3: MSB decided on second edge after start sampled low
    @(negedge clk);
    chk(!ser_oe && trial == 10'h200, "R3 arm cycle", int'(ser_oe), 0);
    n = 0;
    while (!done && n < 40) begin @(negedge clk); n++; end
    chk(n == (f ? 11 : 9), "R7 cycles to done", n, f ? 11 : 9);
    exp_code = f ? tgt : ((tgt & 'h3fc) | 2);
    chk(int'(trial) == exp_code, f ? "R5 full code" : "R6 short code", int'(trial), exp_code);
    chk(sync_cnt == (f ? 10 : 8), "R9 sync edges", sync_cnt, f ? 10 : 8);
    repeat (4) @(negedge clk);
    chk(int'(trial) == exp_code && done, "R11 hold", int'(trial), exp_code);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    m_on = 1;
    chk(trial == 0 && done && !ser_oe, "R1 reset", int'(trial), 0);
    rst_n = 1'b1;
    convert(0, 1, -1);
    convert(1023, 1, -1);
    convert(512, 1, -1);
    convert(341, 1, -1);
    convert(1023, 0, -1);
    convert(3, 0, -1);
    convert(686, 0, -1);
    for (int i = 0; i < 8; i++) convert($urandom_range(0, 1023), i[0], -1);
    convert(777, 1, 4);   // R2 restart a few bits in
    convert(201, 1, 10);  // R2 restart on the final decision edge
    convert(455, 0, 8);   // restart on last short-mode decision
    // R10: lanes and status gated off
    @(negedge clk);
    hi_en = 1'b0;
    @(negedge clk);
    chk(rd_data[9:8] == 2'b00 && !rd_hi_oe, "R10 hi lane off", int'(rd_data), 0);
    lo_en = 1'b0; st_en = 1'b0;
    @(negedge clk);
    chk(rd_data == 0 && !done && !done_oe, "R10 all off", int'(rd_data), 0);
    hi_en = 1'b1; lo_en = 1'b1; st_en = 1'b1;
    @(negedge clk);
    chk(int'(rd_data) == ((455 & 'h3fc) | 2), "R10 lanes back", int'(rd_data), (455 & 'h3fc) | 2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule